// File: doc/BRIEF.md
# Bitstream Repetition Limit Cycle Detector

This block watches the one-bit output stream of a noise-shaping modulator and flags when that stream has started to repeat. It uses only shift registers and bit comparisons. A live register holds the most recent `LEN` accepted bits. Every `INTERVAL` accepted bits, a snapshot of the live register is taken as a reference. On each accepted bit the shifted live contents are compared with the reference, all bits in parallel. When every bit agrees, `detect` is raised. Downstream logic can use that pulse to disturb the modulator and break the cycle.

Each bit is accepted only when `sample_vld` is high, so nothing in the block runs faster than the sample rate. The block has two registers and one small counter. It can still report repetition of any period up to `INTERVAL`, including periods longer than `LEN`. A new cycle is reported no sooner than `LEN` samples after it starts, because the live register must first fill with cyclic output.

Top module: `lc_repeat_detector`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `detect` is 0. Reset clears the live register to all zeros, clears the accepted-sample count and marks the reference as empty.
- R2: A cycle with `sample_vld` low does not shift the live register, does not advance the sample count and does not touch the reference. The `detect` value in the following cycle is 0.
- R3: The reference is loaded on every `INTERVAL`-th accepted sample (the INTERVAL-th, the 2·INTERVAL-th, and so on). The value loaded is the live contents after that sample has been shifted in.
- R4: For each accepted sample, `detect` in the next cycle is 1 exactly when the reference is loaded and all `LEN` bits of the shifted live register equal the reference. The newest bit enters at position 0 and older bits move toward position LEN-1.
- R5: No detection is reported for any sample accepted while the reference has not yet been loaded since reset.
- R6: On the sample that reloads the reference, the comparison uses the reference held before the reload. The reload therefore never causes a match with itself.
- R7: A stream with any period P, where P is no greater than `INTERVAL` and may exceed `LEN`, produces `detect` pulses once the live register holds cyclic data.
- R8: If any one of the `LEN` compared bits differs from the reference, `detect` is not raised for that sample.
- R9: `detect` is high for one cycle per matching accepted sample. It is never high in a cycle that does not follow an accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Marks a cycle that carries a new modulator output bit |
| sample_bit | input | 1 | Modulator output bit, taken when `sample_vld` is high |
| detect | output | 1 | Registered pulse: the last accepted sample completed a full-width match |

## Verification
The assertions assume that `sample_vld` and `sample_bit` are driven to known values in every cycle once reset is released. They also assume that reset is held for at least one clock edge before any stream starts. The stimulus meets both assumptions: inputs are driven away from the clock edge with defined values, including on idle cycles, and reset is held for several cycles first. The stream mixes periodic patterns of different lengths, idle gaps chosen by a pseudo-random sequence, and deliberately corrupted bits. These are chosen so that reloads of the reference fall both inside cyclic stretches and inside non-cyclic stretches.

// File: rtl/lc_repeat_pkg.sv
package lc_repeat_pkg;

    typedef enum logic {
        REF_EMPTY = 1'b0,
        REF_VALID = 1'b1
    } ref_state_e;

    function automatic int unsigned group_count(input int unsigned width,
                                                input int unsigned grp);
        return (width + grp - 1) / grp;
    endfunction

endpackage

// File: rtl/lc_live_shift.sv
module lc_live_shift #(
    parameter int unsigned LEN = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic           bit_in,
    output logic [LEN-1:0] live_q,
    output logic [LEN-1:0] live_next
);
    typedef struct packed {
        logic [LEN-1:0] bits;
    } live_t;

    live_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        live_next = {st_q.bits[LEN-2:0], bit_in};
        if (take) begin
            st_d.bits = live_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_q = st_q.bits;
endmodule

// File: rtl/lc_copy_timer.sv
module lc_copy_timer
    import lc_repeat_pkg::*;
#(
    parameter int unsigned INTERVAL = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic copy_now,
    output logic loaded_q
);
    localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ref_state_e       state;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        copy_now = take && (st_q.cnt == LAST);
        if (take) begin
            if (copy_now) begin
                st_d.cnt   = '0;
                st_d.state = REF_VALID;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, state: REF_EMPTY};
        end else begin
            st_q <= st_d;
        end
    end

    assign loaded_q = (st_q.state == REF_VALID);
endmodule

// File: rtl/lc_ref_hold.sv
module lc_ref_hold #(
    parameter int unsigned LEN = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] load_val,
    output logic [LEN-1:0] ref_q
);
    typedef struct packed {
        logic [LEN-1:0] bits;
    } ref_t;

    ref_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bits = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_q = st_q.bits;
endmodule

// File: rtl/lc_match_tree.sv
module lc_match_tree
    import lc_repeat_pkg::*;
#(
    parameter int unsigned LEN = 64,
    parameter int unsigned GRP = 8
) (
    input  logic [LEN-1:0] a,
    input  logic [LEN-1:0] b,
    output logic           all_eq
);
    localparam int unsigned NGRP = group_count(LEN, GRP);
    localparam int unsigned PADW = NGRP * GRP;

    logic [PADW-1:0] eq_bits;
    logic [NGRP-1:0] grp_ok;

    always_comb begin
        eq_bits          = '1;
        eq_bits[LEN-1:0] = ~(a ^ b);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_ok[g] = &eq_bits[g*GRP +: GRP];
    end

    assign all_eq = &grp_ok;
endmodule

// File: rtl/lc_repeat_detector.sv
module lc_repeat_detector #(
    parameter int unsigned LEN      = 64,
    parameter int unsigned INTERVAL = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_vld,
    input  logic sample_bit,
    output logic detect
);
    typedef struct packed {
        logic hit;
    } top_t;

    top_t           st_d, st_q;
    logic [LEN-1:0] live_bits;
    logic [LEN-1:0] live_next;
    logic [LEN-1:0] ref_bits;
    logic           copy_now;
    logic           ref_loaded;
    logic           all_eq;

    lc_live_shift #(.LEN(LEN)) live_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (sample_vld),
        .bit_in   (sample_bit),
        .live_q   (live_bits),
        .live_next(live_next)
    );

    lc_copy_timer #(.INTERVAL(INTERVAL)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (sample_vld),
        .copy_now(copy_now),
        .loaded_q(ref_loaded)
    );

    lc_ref_hold #(.LEN(LEN)) ref_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (copy_now),
        .load_val(live_next),
        .ref_q   (ref_bits)
    );

    lc_match_tree #(.LEN(LEN), .GRP(8)) match_i (
        .a     (live_next),
        .b     (ref_bits),
        .all_eq(all_eq)
    );

    always_comb begin
        st_d.hit = sample_vld && ref_loaded && all_eq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign detect = st_q.hit;
endmodule

// File: rtl/lc_repeat_detector_chk.sv
module lc_repeat_detector_chk #(
    parameter int unsigned LEN = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sample_vld,
    input logic           detect,
    input logic [LEN-1:0] live,
    input logic [LEN-1:0] ref_bits,
    input logic           loaded
);
    // R9: an idle cycle is never followed by a detect
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> !detect);

    // R2: idle cycles leave the live register untouched
    p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(live));

    // R3: the reference changes only on accepted samples
    p_ref_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(ref_bits));

    // R5: no detect while the reference has never been loaded
    p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |=> !detect);

    // R4: a detect means the new live contents equal the earlier reference
    p_full_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        detect |-> (live == $past(ref_bits)));
endmodule

bind lc_repeat_detector lc_repeat_detector_chk #(.LEN(LEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_vld(sample_vld),
    .detect    (detect),
    .live      (live_bits),
    .ref_bits  (ref_bits),
    .loaded    (ref_loaded)
);

// File: tb/lc_repeat_detector_tb_top.sv
module lc_repeat_detector_tb_top;
    localparam int unsigned TB_LEN = 16;
    localparam int unsigned TB_INT = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_vld = 1'b0;
    logic sample_bit = 1'b0;
    logic detect;

    int checks = 0;
    int errors = 0;
    int hits = 0;
    int cycles = 0;
    bit done = 1'b0;

    bit live_m[$];
    bit ref_m[$];
    bit loaded_m = 1'b0;
    int cnt_m = 0;
    bit exp_det = 1'b0;
    string exp_tag = "R1";
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    lc_repeat_detector #(.LEN(TB_LEN), .INTERVAL(TB_INT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_vld(sample_vld),
        .sample_bit(sample_bit),
        .detect    (detect)
    );

    function automatic bit next_rand();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // one clock: check the previous expectation, then drive and model the next one
    task automatic step(input bit v, input bit b, input string tag);
        bit same;
        @(negedge clk);
        check(detect === exp_det, exp_tag, int'(detect), int'(exp_det));
        if (exp_det) hits++;
        sample_vld = v;
        sample_bit = b;
        if (!v) begin
            exp_det = 1'b0;
            exp_tag = "R2/R9";
        end else begin
            live_m.push_back(b);
            void'(live_m.pop_front());
            same = loaded_m;
            for (int i = 0; i < TB_LEN; i++) begin
                if (live_m[i] != ref_m[i]) same = 1'b0;
            end
            if (!loaded_m) exp_tag = "R5";
            else if (cnt_m == TB_INT - 1) exp_tag = "R6";
            else exp_tag = tag;
            exp_det = same;
            if (cnt_m == TB_INT - 1) begin
                ref_m = live_m;
                loaded_m = 1'b1;
                cnt_m = 0;
            end else begin
                cnt_m++;
            end
        end
    endtask

    task automatic run_period(input int p, input int n, input bit gaps,
                              input int corrupt_every, input string tag);
        bit pat[];
        int k = 0;
        pat = new[p];
        for (int i = 0; i < p; i++) pat[i] = next_rand();
        for (int c = 0; c < n; c++) begin
            if (gaps && next_rand()) begin
                step(1'b0, next_rand(), tag);
            end else begin
                bit b = pat[k % p];
                if (corrupt_every > 0 && (k % corrupt_every) == corrupt_every - 1) b = ~b;
                step(1'b1, b, tag);
                k++;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < TB_LEN; i++) begin
            live_m.push_back(1'b0);
            ref_m.push_back(1'b0);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(detect === 1'b0, "R1", int'(detect), 0);
        rst_n = 1'b1;
        exp_det = 1'b0;
        exp_tag = "R1";

        hits = 0;
        run_period(5, 260, 1'b0, 0, "R4");
        check(hits > 0, "R3 periodic hits", hits, 1);

        hits = 0;
        run_period(40, 320, 1'b0, 0, "R7");
        check(hits > 0, "R7 long period hits", hits, 1);

        hits = 0;
        run_period(7, 500, 1'b1, 0, "R2");
        check(hits > 0, "R9 gapped hits", hits, 1);

        run_period(64, 200, 1'b0, 0, "R7");
        run_period(6, 300, 1'b0, 13, "R8");
        for (int i = 0; i < 300; i++) step(1'b1, next_rand(), "R8");
        step(1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, "R9");
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end
endmodule